// File: doc/BRIEF.md
# Instruction-Namespace Select Register

This block is a control register that picks the namespace the instruction decoder works in. Its contents act as hidden opcode bits that the decoder joins to every fetched instruction. The lowest bit picks the architecture class. When that bit is zero, the register holds a native layout with a binary page number for the 16-bit opcode space and a byte-order bit for those opcodes. When that bit is one, the rest of the register is a binary index that names a single foreign architecture. The two layouts never apply at the same time.

Software writes the register through a CSR port that has an address-match strobe. An implementation states what it supports with a capability table: one bit per page, one bit for big-endian support and one bit per foreign index. A write is accepted only when every field names a supported option, reserved bits are zero and no padding bit of the selected layout is set. Any other write raises an illegal-instruction trap in the same cycle and leaves the register unchanged. The trap is never replaced by silent masking, because software emulation is started by that trap. An accepted write takes effect as a whole at the next clock edge, so the next decoded instruction sees the new namespace.

Top module: `nsc_csr`

## Requirements
- R1: After reset the register reads zero. The decoder outputs then show native class, page 0 (the standard compressed encoding), little-endian, foreign index 0 and not custom, and the trap output is low.
- R2: In native class (bit 0 = 0) the page field is bits 5..1 and the byte-order bit is bit 6 (1 = big-endian). A write is accepted when the capability bit of the page is set and, if bit 6 is 1, big-endian is supported. The value can be read back, and the outputs show it, from the cycle after the write edge.
- R3: A write with any bit from 31 down to 15 set raises the trap in its own cycle and leaves the register unchanged.
- R4: A native-class write that names a page whose capability bit is clear, or that sets bit 6 while big-endian is not supported, raises the trap and leaves the register unchanged.
- R5: A native-class write with any of bits 14..7 set raises the trap and leaves the register unchanged.
- R6: In foreign class (bit 0 = 1) bits 7..1 are a binary foreign index, and a write is accepted when the capability bit of that index is set. While foreign class is held, the page output and the byte-order output are zero.
- R7: A foreign-class write that names an unsupported index, or that has any of bits 14..8 set, raises the trap and leaves the register unchanged.
- R8: A write with the address strobe low, or a cycle with the strobe high and the write enable low, raises no trap and does not change the register.
- R9: In the cycle of a write, the read data and the decoder outputs still show the old value. The new value appears in every field together on the next cycle.
- R10: The custom output equals page bit 4 (register bit 5) in native class and index bit 6 (register bit 7) in foreign class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_sel | input | 1 | CSR address matches this register |
| csr_wr | input | 1 | Write enable of the CSR access |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Held value, reserved bits zero |
| trap_illegal | output | 1 | Illegal-instruction trap for a rejected write |
| cap_page | input | 32 | One bit per supported 16-bit opcode page |
| cap_be | input | 1 | Big-endian 16-bit opcodes supported |
| cap_foreign | input | 128 | One bit per supported foreign index |
| ns_foreign | output | 1 | Architecture class: 1 = foreign |
| ns_page | output | 5 | Active 16-bit opcode page |
| ns_big_endian | output | 1 | 16-bit opcodes are big-endian |
| ns_foreign_idx | output | 7 | Active foreign architecture index |
| ns_custom | output | 1 | Active namespace is a custom one |

## Verification
The bench builds the block with its default parameters, XLEN 32 and reserved boundary at bit 15. With these values every field position is fixed and reserved-bit writes at both ends of the reserved range can be reached. The capability table is a set of input ports, so the bench drives a sparse pattern: pages 0, 1, 2 and 16 and foreign indices 0, 1, 3 and 64. It also turns big-endian support off for one write. Accepted and rejected cases of each layout, including the custom halves, then sit a single write apart.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    // Field layout of the namespace word (positions are decoded by the decoder)
    localparam int NSC_PAGE_W   = 5;
    localparam int NSC_IDX_W    = 7;
    localparam int NSC_MODE_BIT = 0;
    localparam int NSC_PAGE_LSB = 1;
    localparam int NSC_BE_BIT   = NSC_PAGE_LSB + NSC_PAGE_W;
    localparam int NSC_IDX_LSB  = 1;
    localparam int NSC_IDX_MSB  = NSC_IDX_LSB + NSC_IDX_W - 1;
    localparam int NSC_VIEW_W   = NSC_IDX_MSB + 1;
    localparam int NSC_PAGES    = 1 << NSC_PAGE_W;
    localparam int NSC_FOREIGNS = 1 << NSC_IDX_W;

    typedef enum logic {
        NS_MODE_RV      = 1'b0,
        NS_MODE_FOREIGN = 1'b1
    } ns_mode_e;

    typedef enum logic [2:0] {
        VERDICT_OK,
        VERDICT_RESERVED,
        VERDICT_RV_PAD,
        VERDICT_PAGE,
        VERDICT_ENDIAN,
        VERDICT_FRN_PAD,
        VERDICT_INDEX
    } verdict_e;

    typedef struct packed {
        ns_mode_e               mode;
        logic [NSC_PAGE_W-1:0]  page;
        logic                   big_endian;
        logic [NSC_IDX_W-1:0]   idx;
        logic                   custom;
    } ns_view_t;

endpackage

// File: rtl/nsc_legal_check.sv
module nsc_legal_check
    import nsc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int RSV_LSB = 15
) (
    input  logic [XLEN-1:0]         word,
    input  logic [NSC_PAGES-1:0]    cap_page,
    input  logic                    cap_be,
    input  logic [NSC_FOREIGNS-1:0] cap_foreign,
    output logic                    ok
);

    localparam int RV_PAD_LSB  = NSC_BE_BIT + 1;
    localparam int FRN_PAD_LSB = NSC_IDX_MSB + 1;

    verdict_e              verdict;
    logic                  rsv_set;
    logic                  rv_pad_set;
    logic                  frn_pad_set;
    logic [NSC_PAGE_W-1:0] page_f;
    logic [NSC_IDX_W-1:0]  idx_f;

    assign rsv_set     = |word[XLEN-1:RSV_LSB];
    assign rv_pad_set  = |word[RSV_LSB-1:RV_PAD_LSB];
    assign frn_pad_set = |word[RSV_LSB-1:FRN_PAD_LSB];
    assign page_f      = word[NSC_BE_BIT-1:NSC_PAGE_LSB];
    assign idx_f       = word[NSC_IDX_MSB:NSC_IDX_LSB];

    always_comb begin
        verdict = VERDICT_OK;
        if (rsv_set) begin
            verdict = VERDICT_RESERVED;
        end else if (word[NSC_MODE_BIT] == NS_MODE_RV) begin
            if (rv_pad_set)                       verdict = VERDICT_RV_PAD;
            else if (!cap_page[page_f])           verdict = VERDICT_PAGE;
            else if (word[NSC_BE_BIT] && !cap_be) verdict = VERDICT_ENDIAN;
        end else begin
            if (frn_pad_set)                      verdict = VERDICT_FRN_PAD;
            else if (!cap_foreign[idx_f])         verdict = VERDICT_INDEX;
        end
    end

    assign ok = (verdict == VERDICT_OK);

endmodule

// File: rtl/nsc_field_view.sv
module nsc_field_view
    import nsc_pkg::*;
(
    input  logic [NSC_VIEW_W-1:0] held,
    output ns_view_t              view
);

    always_comb begin
        view = '0;
        if (held[NSC_MODE_BIT] == NS_MODE_RV) begin
            view.mode       = NS_MODE_RV;
            view.page       = held[NSC_BE_BIT-1:NSC_PAGE_LSB];
            view.big_endian = held[NSC_BE_BIT];
            view.custom     = held[NSC_BE_BIT-1];
        end else begin
            view.mode       = NS_MODE_FOREIGN;
            view.idx        = held[NSC_IDX_MSB:NSC_IDX_LSB];
            view.custom     = held[NSC_IDX_MSB];
        end
    end

endmodule

// File: rtl/nsc_csr.sv
module nsc_csr
    import nsc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int RSV_LSB = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csr_sel,
    input  logic                    csr_wr,
    input  logic [XLEN-1:0]         csr_wdata,
    output logic [XLEN-1:0]         csr_rdata,
    output logic                    trap_illegal,
    input  logic [NSC_PAGES-1:0]    cap_page,
    input  logic                    cap_be,
    input  logic [NSC_FOREIGNS-1:0] cap_foreign,
    output logic                    ns_foreign,
    output logic [NSC_PAGE_W-1:0]   ns_page,
    output logic                    ns_big_endian,
    output logic [NSC_IDX_W-1:0]    ns_foreign_idx,
    output logic                    ns_custom
);

    localparam int HOLD_W = RSV_LSB;
    localparam int ZERO_W = XLEN - RSV_LSB;

    typedef struct packed {
        logic [HOLD_W-1:0] ns;
    } state_t;

    state_t   st_d, st_q;
    logic     wr_fire;
    logic     word_ok;
    ns_view_t view;

    nsc_legal_check #(
        .XLEN    (XLEN),
        .RSV_LSB (RSV_LSB)
    ) u_legal (
        .word        (csr_wdata),
        .cap_page    (cap_page),
        .cap_be      (cap_be),
        .cap_foreign (cap_foreign),
        .ok          (word_ok)
    );

    always_comb begin
        st_d         = st_q;
        wr_fire      = csr_sel && csr_wr;
        trap_illegal = wr_fire && !word_ok;
        if (wr_fire && word_ok) begin
            st_d.ns = csr_wdata[HOLD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nsc_field_view u_view (
        .held (st_q.ns[NSC_VIEW_W-1:0]),
        .view (view)
    );

    assign csr_rdata      = {{ZERO_W{1'b0}}, st_q.ns};
    assign ns_foreign     = (view.mode == NS_MODE_FOREIGN);
    assign ns_page        = view.page;
    assign ns_big_endian  = view.big_endian;
    assign ns_foreign_idx = view.idx;
    assign ns_custom      = view.custom;

endmodule

// File: rtl/nsc_csr_chk.sv
module nsc_csr_chk
    import nsc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int RSV_LSB = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  csr_sel,
    input logic                  csr_wr,
    input logic [XLEN-1:0]       csr_wdata,
    input logic [XLEN-1:0]       csr_rdata,
    input logic                  trap_illegal,
    input logic                  ns_foreign,
    input logic [NSC_PAGE_W-1:0] ns_page,
    input logic                  ns_big_endian
);

    // R3: reserved bits in a write always trap
    a_r3_reserved_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel && csr_wr && (|csr_wdata[XLEN-1:RSV_LSB])) |-> trap_illegal);

    // R4: a trapped write leaves the held value unchanged
    a_r4_trap_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
        trap_illegal |=> (csr_rdata == $past(csr_rdata)));

    // R8: no trap without a selected write
    a_r8_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_sel && csr_wr) |-> !trap_illegal);

    // R2: an accepted write is read back on the next cycle
    a_r2_accept_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel && csr_wr && !trap_illegal) |=> (csr_rdata == $past(csr_wdata)));

    // R3: reserved bits always read as zero
    a_r3_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[XLEN-1:RSV_LSB] == '0);

    // R6: foreign class never exposes native fields
    a_r6_foreign_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ns_foreign |-> (ns_page == '0 && !ns_big_endian));

endmodule

bind nsc_csr nsc_csr_chk #(
    .XLEN    (XLEN),
    .RSV_LSB (RSV_LSB)
) u_nsc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_sel       (csr_sel),
    .csr_wr        (csr_wr),
    .csr_wdata     (csr_wdata),
    .csr_rdata     (csr_rdata),
    .trap_illegal  (trap_illegal),
    .ns_foreign    (ns_foreign),
    .ns_page       (ns_page),
    .ns_big_endian (ns_big_endian)
);

// File: tb/tb_nsc_csr.sv
module tb_nsc_csr;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         csr_sel = 1'b0;
    logic         csr_wr = 1'b0;
    logic [31:0]  csr_wdata = '0;
    logic [31:0]  csr_rdata;
    logic         trap_illegal;
    logic [31:0]  cap_page;
    logic         cap_be;
    logic [127:0] cap_foreign;
    logic         ns_foreign;
    logic [4:0]   ns_page;
    logic         ns_big_endian;
    logic [6:0]   ns_foreign_idx;
    logic         ns_custom;

    int checks = 0;
    int fails  = 0;
    logic [31:0] held = '0;

    always #4 clk = ~clk;

    nsc_csr dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .csr_sel        (csr_sel),
        .csr_wr         (csr_wr),
        .csr_wdata      (csr_wdata),
        .csr_rdata      (csr_rdata),
        .trap_illegal   (trap_illegal),
        .cap_page       (cap_page),
        .cap_be         (cap_be),
        .cap_foreign    (cap_foreign),
        .ns_foreign     (ns_foreign),
        .ns_page        (ns_page),
        .ns_big_endian  (ns_big_endian),
        .ns_foreign_idx (ns_foreign_idx),
        .ns_custom      (ns_custom)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_fields(input string tag, input logic frn, input logic [4:0] pg,
                              input logic be, input logic [6:0] idx, input logic cust);
        chk({tag, " class"},  {31'd0, ns_foreign},    {31'd0, frn});
        chk({tag, " page"},   {27'd0, ns_page},       {27'd0, pg});
        chk({tag, " endian"}, {31'd0, ns_big_endian}, {31'd0, be});
        chk({tag, " index"},  {25'd0, ns_foreign_idx},{25'd0, idx});
        chk({tag, " custom"}, {31'd0, ns_custom},     {31'd0, cust});
    endtask

    // One selected write; checks trap and old value in its cycle, new value after
    task automatic do_write(input string tag, input logic [31:0] v, input logic accept);
        @(negedge clk);
        csr_sel = 1'b1; csr_wr = 1'b1; csr_wdata = v;
        #1;
        chk({tag, " trap"}, {31'd0, trap_illegal}, {31'd0, !accept});
        chk({tag, " R9 old value during write"}, csr_rdata, held);
        @(negedge clk);
        csr_sel = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
        if (accept) held = v;
        #1;
        chk({tag, " readback"}, csr_rdata, held);
    endtask

    task automatic t_reset;
        chk("R1 reset read", csr_rdata, 32'h0);
        chk("R1 reset trap", {31'd0, trap_illegal}, 32'h0);
        chk_fields("R1 reset", 1'b0, 5'd0, 1'b0, 7'd0, 1'b0);
    endtask

    task automatic t_native_legal;
        do_write("R2 page1", 32'h0000_0002, 1'b1);
        chk_fields("R2 page1", 1'b0, 5'd1, 1'b0, 7'd0, 1'b0);
        do_write("R2 page16 big-endian", 32'h0000_0060, 1'b1);
        chk_fields("R10 custom page", 1'b0, 5'd16, 1'b1, 7'd0, 1'b1);
    endtask

    task automatic t_native_illegal;
        do_write("R4 page3 unsupported", 32'h0000_0006, 1'b0);
        cap_be = 1'b0;
        do_write("R4 big-endian unsupported", 32'h0000_0042, 1'b0);
        cap_be = 1'b1;
        do_write("R5 pad bit7", 32'h0000_0082, 1'b0);
        do_write("R5 pad bit14", 32'h0000_4002, 1'b0);
        chk_fields("R4 after rejects", 1'b0, 5'd16, 1'b1, 7'd0, 1'b1);
    endtask

    task automatic t_reserved;
        do_write("R3 bit15", 32'h0000_8002, 1'b0);
        do_write("R3 bit31", 32'h8000_0002, 1'b0);
        do_write("R3 bit15 foreign", 32'h0000_8007, 1'b0);
    endtask

    task automatic t_foreign;
        do_write("R6 index3", 32'h0000_0007, 1'b1);
        chk_fields("R6 index3", 1'b1, 5'd0, 1'b0, 7'd3, 1'b0);
        do_write("R6 index64", 32'h0000_0081, 1'b1);
        chk_fields("R10 custom foreign", 1'b1, 5'd0, 1'b0, 7'd64, 1'b1);
        do_write("R7 index2 unsupported", 32'h0000_0005, 1'b0);
        do_write("R7 pad bit8", 32'h0000_0107, 1'b0);
        chk_fields("R7 after rejects", 1'b1, 5'd0, 1'b0, 7'd64, 1'b1);
    endtask

    task automatic t_no_access;
        @(negedge clk);
        csr_sel = 1'b0; csr_wr = 1'b1; csr_wdata = 32'h0000_0002;
        #1;
        chk("R8 unselected trap", {31'd0, trap_illegal}, 32'h0);
        @(negedge clk);
        csr_sel = 1'b1; csr_wr = 1'b0; csr_wdata = 32'h0000_8000;
        #1;
        chk("R8 read-only trap", {31'd0, trap_illegal}, 32'h0);
        @(negedge clk);
        csr_sel = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
        #1;
        chk("R8 value kept", csr_rdata, held);
    endtask

    task automatic t_return;
        do_write("R9 back to standard page", 32'h0000_0000, 1'b1);
        chk_fields("R9 standard page", 1'b0, 5'd0, 1'b0, 7'd0, 1'b0);
    endtask

    initial begin
        cap_page    = 32'h0001_0007;
        cap_be      = 1'b1;
        cap_foreign = '0;
        cap_foreign[0]  = 1'b1;
        cap_foreign[1]  = 1'b1;
        cap_foreign[3]  = 1'b1;
        cap_foreign[64] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_native_legal;
        t_native_illegal;
        t_reserved;
        t_foreign;
        t_no_access;
        t_return;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule